// File: doc/BRIEF.md
# Scanline sprite evaluation engine

This block decides, once per display line, which sprites show on that line and gathers what the pixel stage needs to draw them. A line-start pulse latches the line number and a programmable sprite count M. In the first burst the engine reads M 16-bit Y coordinates from a table in video memory. It compares each one against the line and records the index of every sprite that covers the line in a hit queue with a fixed capacity.

The first burst then ends and the bus request is released. A second burst follows. For each queued sprite, in queue order, it reads three consecutive words from an attribute table: horizontal position, colour, and the single 16-bit raster word of a monochrome 16-pixel sprite. These words land in per-entry registers that the compositor reads directly.

The engine counts the memory transfers it used on the line. This lets the line budget of M plus three per visible sprite be confirmed at run time. It raises done when both bursts are finished. A line-start that arrives before done restarts the work on the new line and flags that the previous line was cut short.

Top module: `sprite_line_eval`

## Requirements
- R1: When the count latched at line-start is zero, the engine makes no memory request, and done is high one clock after the line-start with slots_used and vis_count at zero.
- R2: The first burst reads exactly M words, at addresses ybase+0, ybase+1, ... ybase+M-1 in that order; a word is taken on a clock where mem_req, mem_gnt and mem_ack are all high.
- R3: A sprite is visible when (line − Y) taken modulo 2^16 is below 16, so Y values up to 15 lines above the line hit, including values that wrap below line 0.
- R4: Visible sprite indices are queued in ascending index order, up to 16 entries; further hits are dropped, and overflow goes high and stays high until the next line-start. vis_count gives the number of queued entries.
- R5: The second burst reads, for each queue entry j holding sprite s, the words abase+3s (horizontal position), abase+3s+1 (colour) and abase+3s+2 (raster) in that order. It stores them with s in entry j of spr_x, spr_color, spr_bits and spr_idx (entry j at bits 16j and up, or IW·j for the index).
- R6: At done, slots_used equals M + 3·vis_count.
- R7: mem_req stays high through a burst and mem_addr holds while a word is awaited. mem_req drops for at least one clock between the two bursts, and no second burst is made when nothing was queued.
- R8: done stays high, with mem_req low, until the next line-start.
- R9: A line-start while the engine is busy restarts evaluation for the new line and sets err_abort; a line-start while idle or done clears err_abort.
- R10: After reset, done, mem_req, err_abort, overflow, vis_count and slots_used are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-clock pulse that starts a line |
| line_num | input | 16 | Line about to be displayed, latched at line_start |
| cfg_count | input | CW | Number of sprites M to scan, latched at line_start |
| cfg_ybase | input | AW | Word address of the Y coordinate table |
| cfg_abase | input | AW | Word address of the attribute table (3 words per sprite) |
| mem_req | output | 1 | Bus request, held for a whole burst |
| mem_gnt | input | 1 | Bus grant |
| mem_addr | output | AW | Word address of the current transfer |
| mem_rdata | input | 16 | Read data |
| mem_ack | input | 1 | Transfer completes with data valid |
| done | output | 1 | Both phases finished for this line |
| err_abort | output | 1 | Previous line was cut short by a new line-start |
| overflow | output | 1 | More hits than queue entries |
| vis_count | output | QW | Number of queued visible sprites |
| slots_used | output | SW | Memory transfers used on this line |
| spr_idx | output | QD·IW | Sprite index per queue entry |
| spr_x | output | QD·16 | Horizontal position per entry |
| spr_color | output | QD·16 | Colour word per entry |
| spr_bits | output | QD·16 | Raster word per entry |

## Verification
A spread Y table, one sprite every five lines, is swept across many consecutive lines. This moves sprites in and out of the 16-line window one line at a time and separates an off-by-one window from a correct one. A descending table placing sprite k at distance k from the line separates the last visible row from the first invisible one, and near line 0 it makes the subtraction wrap. Tables where every sprite hits fill and overflow the queue, and tables lying just below the line give no hits at all, which checks that the second burst is skipped. Runs with M of zero, bus stalls alternating with full-rate acknowledges, and a line-start that lands mid-burst check the request, budget and abort behaviour.

// File: rtl/sprite_line_eval.sv
module sprite_line_eval #(
  parameter int AW    = 16,
  parameter int MAXM  = 64,
  parameter int QD    = 16,
  parameter int SPR_H = 16,
  localparam int CW = $clog2(MAXM + 1),
  localparam int IW = (MAXM > 1) ? $clog2(MAXM) : 1,
  localparam int QW = $clog2(QD + 1),
  localparam int PW = (QD > 1) ? $clog2(QD) : 1,
  localparam int SW = $clog2(MAXM + 3 * QD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [15:0]      line_num,
  input  logic [CW-1:0]    cfg_count,
  input  logic [AW-1:0]    cfg_ybase,
  input  logic [AW-1:0]    cfg_abase,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic [AW-1:0]    mem_addr,
  input  logic [15:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             done,
  output logic             err_abort,
  output logic             overflow,
  output logic [QW-1:0]    vis_count,
  output logic [SW-1:0]    slots_used,
  output logic [QD*IW-1:0] spr_idx,
  output logic [QD*16-1:0] spr_x,
  output logic [QD*16-1:0] spr_color,
  output logic [QD*16-1:0] spr_bits
);

  typedef enum logic [2:0] {S_IDLE, S_Y, S_GAP, S_ATTR, S_DONE} st_t;

  st_t            st;
  logic [CW-1:0]  m_q, yi;
  logic [QW-1:0]  qcnt;
  logic [PW-1:0]  qi;
  logic [1:0]     w;
  logic [15:0]    line_q;
  logic [AW-1:0]  yb_q, ab_q;
  logic [SW-1:0]  slots;
  logic           ovf, err;
  logic [IW-1:0]  qidx  [QD];
  logic [15:0]    sx    [QD];
  logic [15:0]    scol  [QD];
  logic [15:0]    sbits [QD];

  wire         take   = mem_req & mem_gnt & mem_ack;
  wire         busy   = (st == S_Y) || (st == S_GAP) || (st == S_ATTR);
  wire  [15:0] dy     = line_q - mem_rdata;
  wire         hit    = dy < 16'(SPR_H);
  wire         push   = hit && (qcnt < QW'(QD));
  wire [QW-1:0] qnext = qcnt + QW'(push);

  assign mem_req    = (st == S_Y) || (st == S_ATTR);
  assign mem_addr   = (st == S_ATTR) ? ab_q + AW'(qidx[qi]) * AW'(3) + AW'(w)
                                     : yb_q + AW'(yi);
  assign done       = (st == S_DONE);
  assign err_abort  = err;
  assign overflow   = ovf;
  assign vis_count  = qcnt;
  assign slots_used = slots;

  for (genvar j = 0; j < QD; j++) begin : g_out
    assign spr_idx  [IW*j +: IW] = qidx[j];
    assign spr_x    [16*j +: 16] = sx[j];
    assign spr_color[16*j +: 16] = scol[j];
    assign spr_bits [16*j +: 16] = sbits[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      m_q    <= '0;
      yi     <= '0;
      qcnt   <= '0;
      qi     <= '0;
      w      <= '0;
      line_q <= '0;
      yb_q   <= '0;
      ab_q   <= '0;
      slots  <= '0;
      ovf    <= 1'b0;
      err    <= 1'b0;
    end else if (line_start) begin
      err    <= busy;
      st     <= (cfg_count == '0) ? S_DONE : S_Y;
      m_q    <= cfg_count;
      yi     <= '0;
      qcnt   <= '0;
      qi     <= '0;
      w      <= '0;
      line_q <= line_num;
      yb_q   <= cfg_ybase;
      ab_q   <= cfg_abase;
      slots  <= '0;
      ovf    <= 1'b0;
    end else begin
      case (st)
        S_Y: if (take) begin
          slots <= slots + SW'(1);
          qcnt  <= qnext;
          if (hit && !push) ovf <= 1'b1;
          if (yi == m_q - CW'(1)) st <= (qnext != '0) ? S_GAP : S_DONE;
          else                    yi <= yi + CW'(1);
        end
        S_GAP: st <= S_ATTR;
        S_ATTR: if (take) begin
          slots <= slots + SW'(1);
          if (w == 2'd2) begin
            w <= '0;
            if (QW'(qi) + QW'(1) == qcnt) st <= S_DONE;
            else                          qi <= qi + PW'(1);
          end else begin
            w <= w + 2'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!line_start && st == S_Y && take && push) qidx[qcnt[PW-1:0]] <= yi[IW-1:0];
    if (!line_start && st == S_ATTR && take) begin
      if (w == 2'd0) sx[qi]    <= mem_rdata;
      if (w == 2'd1) scol[qi]  <= mem_rdata;
      if (w == 2'd2) sbits[qi] <= mem_rdata;
    end
  end

  a_r1_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && cfg_count == '0) |=> (done && slots_used == '0 && !mem_req));

  a_r4_queue_cap: assert property (@(posedge clk) disable iff (!rst_n)
    vis_count <= QW'(QD));

  a_r4_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> vis_count == QW'(QD));

  a_r6_slot_total: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> slots_used == SW'(m_q) + SW'(vis_count) * SW'(3));

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !(mem_gnt && mem_ack) && !line_start) |=> (mem_req && $stable(mem_addr)));

  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !line_start) |=> (done && !mem_req));

endmodule

// File: tb/test_sprite_line_eval.sv
module test_sprite_line_eval;
  localparam int PERIOD = 10;
  localparam int AW = 16, MAXM = 64, QD = 16;
  localparam int CW = 7, IW = 6, QW = 5, SW = 7;
  localparam int YB = 0, AB = 64;

  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0;
  logic [15:0] line_num = '0;
  logic [CW-1:0] cfg_count = '0;
  logic mem_req, mem_ack, done, err_abort, overflow;
  logic gnt = 1'b0, cyc = 1'b0, stall = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [QW-1:0] vis_count;
  logic [SW-1:0] slots_used;
  logic [QD*IW-1:0] spr_idx;
  logic [QD*16-1:0] spr_x, spr_color, spr_bits;
  logic [15:0] mem [0:255];

  int errors = 0, checks = 0;
  int exp_addr [0:255];
  int n_exp = 0, ack_n = 0, falls = 0;
  bit addr_bad = 0, prev_req = 0;

  always #(PERIOD/2) clk = ~clk;

  sprite_line_eval i_sprite_line_eval (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .cfg_count(cfg_count), .cfg_ybase(16'(YB)), .cfg_abase(16'(AB)),
    .mem_req(mem_req), .mem_gnt(gnt), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .done(done), .err_abort(err_abort), .overflow(overflow),
    .vis_count(vis_count), .slots_used(slots_used), .spr_idx(spr_idx),
    .spr_x(spr_x), .spr_color(spr_color), .spr_bits(spr_bits));

  assign mem_rdata = mem[mem_addr[7:0]];
  assign mem_ack   = mem_req & gnt & (stall ? cyc : 1'b1);

  always @(negedge clk) begin
    gnt <= mem_req;
    cyc <= ~cyc;
  end

  always @(negedge clk) begin
    #1;
    if (!line_start) begin
      if (mem_ack) begin
        if (ack_n >= n_exp || int'(mem_addr) != exp_addr[ack_n]) addr_bad = 1;
        ack_n++;
      end
      if (prev_req && !mem_req) falls++;
    end
    prev_req = mem_req;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int ypat(int pat, int k, int line);
    case (pat)
      0: return k * 5;
      1: return (line - k) & 16'hFFFF;
      2: return line;
      default: return (line + 1 + k) & 16'hFFFF;
    endcase
  endfunction

  task automatic pulse(input int line, input int m);
    @(negedge clk);
    line_num  = 16'(line);
    cfg_count = CW'(m);
    line_start = 1'b1;
    ack_n = 0; addr_bad = 0; falls = 0;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic run_line(input int line, input int m, input int pat, input bit stl, input bit abort);
    int e [16];
    int v = 0, wd = 0;
    bit ovf = 0;
    stall = stl;
    for (int k = 0; k < m; k++) mem[YB + k] = 16'(ypat(pat, k, line));
    for (int k = 0; k < m; k++) begin
      int d = (line - ypat(pat, k, line)) & 16'hFFFF;
      if (d < 16) begin
        if (v < 16) begin e[v] = k; v++; end
        else ovf = 1;
      end
    end
    n_exp = 0;
    for (int k = 0; k < m; k++) begin exp_addr[n_exp] = YB + k; n_exp++; end
    for (int j = 0; j < v; j++)
      for (int w = 0; w < 3; w++) begin exp_addr[n_exp] = AB + 3 * e[j] + w; n_exp++; end
    if (abort) begin
      pulse(line + 7, m);
      @(negedge clk);
    end
    pulse(line, m);
    while (!done && wd < 3000) begin @(negedge clk); wd++; end
    #2;
    chk(wd < 3000, "R8 done never rose (watchdog)", wd, 3000);
    chk(vis_count == QW'(v), "R3 R4 visible count", int'(vis_count), v);
    chk(overflow == ovf, "R4 overflow flag", int'(overflow), int'(ovf));
    chk(slots_used == SW'(m + 3 * v), "R6 slot total", int'(slots_used), m + 3 * v);
    chk(!addr_bad && ack_n == n_exp, "R2 R5 transfer order", ack_n, n_exp);
    chk(falls == ((m > 0 ? 1 : 0) + (v > 0 ? 1 : 0)), "R7 request bursts", falls,
        (m > 0 ? 1 : 0) + (v > 0 ? 1 : 0));
    chk(err_abort == abort, "R9 abort flag", int'(err_abort), int'(abort));
    for (int j = 0; j < v; j++) begin
      int s = e[j];
      bit ok = spr_idx[IW*j +: IW] == IW'(s) &&
               spr_x[16*j +: 16] == mem[AB + 3*s] &&
               spr_color[16*j +: 16] == mem[AB + 3*s + 1] &&
               spr_bits[16*j +: 16] == mem[AB + 3*s + 2];
      chk(ok, "R5 entry contents", int'(spr_idx[IW*j +: IW]), s);
    end
    if (m == 0) chk(ack_n == 0 && done, "R1 zero count idle", ack_n, 0);
    repeat (3) @(negedge clk);
    chk(done && !mem_req, "R8 done held", int'(done), 1);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 41 + 9);
    for (int i = 0; i < MAXM; i++)
      for (int w = 0; w < 3; w++) mem[AB + 3*i + w] = 16'((w + 1) * 4096 + i * 17 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req && !err_abort && !overflow && vis_count == 0 && slots_used == 0,
        "R10 reset state", int'(done), 0);
    run_line(10, 0, 0, 0, 0);
    run_line(300, 0, 1, 1, 0);
    for (int ln = 0; ln < 170; ln++) run_line(ln, 32, 0, ln[0], 0);
    run_line(100, 64, 0, 1, 0);
    run_line(200, 20, 1, 0, 0);
    run_line(3, 20, 1, 1, 0);
    run_line(0, 17, 1, 0, 0);
    run_line(50, 40, 2, 0, 0);
    run_line(51, 16, 2, 1, 0);
    run_line(52, 1, 2, 0, 0);
    run_line(80, 10, 3, 1, 0);
    run_line(65535, 12, 3, 0, 0);
    run_line(60, 32, 0, 1, 1);
    run_line(61, 32, 0, 0, 0);
    run_line(70, 64, 2, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule